// File: doc/BRIEF.md
# Latchable Inverting Wired-OR Bus Transceiver

This block sits between a 9-bit local logic port and a shared backplane bus whose lines are open-collector. Each bus line can only be pulled low; a line that no agent pulls rests high through its pull-up. Toward the bus the data is inverted. A local high pulls the line low, and a local low releases it. Data going to the bus takes one of two routes. The first is a direct bypass from the local inputs. The second goes through a storage stage with an active-low enable. While that enable is low the stage passes data through, and while it is high the stage keeps the word it saw in the last cycle before the enable rose.

From the bus back to the local side, the resolved wire value is inverted and presented on the local pins under a separate output enable. The bus drivers have two enables of opposite polarity, and they drive only when the first is high and the second is low. Because the local side reads the resolved wire, it also shows lines pulled low by other agents while the device itself is driving.

The model is synchronous to one clock, and every output is registered. Local pins are split into an input vector, an output vector and an output-enable vector. Each bus line is split into the device's pull-low request and the resolved wire input.

Top module: `wor_xcvr`

## Requirements
- R1: With `path_bypass` high and the drivers enabled, `bus_pull` equals `loc_in` one clock later (a local 1 is a pull-low request on that line).
- R2: The drivers are enabled only when `bus_en_p` is 1 and `bus_en_n` is 0. With any other pair, every bit of `bus_pull` is 0 one clock later.
- R3: With `path_bypass` low and `lat_open_n` low, the stored path is transparent: `bus_pull` equals `loc_in` one clock later, and the store takes that word.
- R4: While `lat_open_n` is high, the store keeps the word sampled in the last cycle `lat_open_n` was low. Bypass use, `loc_in` changes and disabled drivers leave that word unchanged.
- R5: `loc_oe` is all ones one clock after `loc_oe_req` is 1 and all zeros one clock after it is 0. While it is zero, `loc_out` is all zeros.
- R6: With `loc_oe_req` high, `loc_out` is the bitwise inverse of `bus_wire` one clock later. A line pulled low by any agent therefore reads 1, even where this device releases it.
- R7: A synchronous active-high `rst` clears `bus_pull`, `loc_out` and `loc_oe` to zero and clears the stored word to zero, which leaves the bus released.
- R8: The bench's wire resolver makes a bus line low exactly when at least one agent requests a pull on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_in | input | 9 | Local port data in |
| loc_out | output | 9 | Local port data out (inverted bus) |
| loc_oe | output | 9 | Local port per-bit output enable |
| path_bypass | input | 1 | 1: bus fed from loc_in directly; 0: through store |
| lat_open_n | input | 1 | Store enable, active low (0 = transparent) |
| bus_en_p | input | 1 | Bus driver enable, active high |
| bus_en_n | input | 1 | Bus driver enable, active low |
| loc_oe_req | input | 1 | Local output enable request, active high |
| bus_wire | input | 9 | Resolved bus line levels (1 = high) |
| bus_pull | output | 9 | Pull-low request per bus line |

## Verification
The hardest case to reach is a stored word that stays intact across other activity. The store must keep it through a bypass phase, through disabled drivers, through a local-disable phase and through changing local data. The word becomes visible again only when the stored path is reselected. The vector table therefore loads a word with the store open, closes the store, runs each of those phases with different `loc_in` values, and then returns to the stored path expecting the original word. A second agent pulls lines the device releases, which shows that the read-back reflects the whole bus.

// File: rtl/wor_xcvr_pkg.sv
package wor_xcvr_pkg;
  typedef enum logic {
    ROUTE_STORED = 1'b0,
    ROUTE_DIRECT = 1'b1
  } route_e;

  function automatic logic drivers_on(input logic en_p, input logic en_n);
    return en_p & ~en_n;
  endfunction
endpackage

// File: rtl/wor_xcvr_store.sv
module wor_xcvr_store #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] view
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (!open_n) begin
      held_q <= d;
    end
  end

  // transparent while open, stored word while closed
  assign view = open_n ? held_q : d;
endmodule

// File: rtl/wor_xcvr_drv.sv
module wor_xcvr_drv #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         route,
  input  logic         en_p,
  input  logic         en_n,
  input  logic [W-1:0] direct_d,
  input  logic [W-1:0] stored_d,
  output logic [W-1:0] pull
);
  import wor_xcvr_pkg::*;

  logic active;
  assign active = drivers_on(en_p, en_n);

  for (genvar i = 0; i < W; i++) begin : g_line
    logic src;
    assign src = (route_e'(route) == ROUTE_DIRECT) ? direct_d[i] : stored_d[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        pull[i] <= 1'b0;
      end else begin
        pull[i] <= active & src;
      end
    end
  end
endmodule

// File: rtl/wor_xcvr_rx.sv
module wor_xcvr_rx #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_req,
  input  logic [W-1:0] wire_lvl,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      oe   <= '0;
    end else begin
      dout <= oe_req ? ~wire_lvl : '0;
      oe   <= {W{oe_req}};
    end
  end
endmodule

// File: rtl/wor_xcvr.sv
module wor_xcvr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] loc_in,
  output logic [W-1:0] loc_out,
  output logic [W-1:0] loc_oe,
  input  logic         path_bypass,
  input  logic         lat_open_n,
  input  logic         bus_en_p,
  input  logic         bus_en_n,
  input  logic         loc_oe_req,
  input  logic [W-1:0] bus_wire,
  output logic [W-1:0] bus_pull
);
  logic [W-1:0] store_view;

  wor_xcvr_store #(.W(W)) store_i (
    .clk(clk), .rst(rst), .open_n(lat_open_n), .d(loc_in), .view(store_view)
  );

  wor_xcvr_drv #(.W(W)) drv_i (
    .clk(clk), .rst(rst), .route(path_bypass), .en_p(bus_en_p), .en_n(bus_en_n),
    .direct_d(loc_in), .stored_d(store_view), .pull(bus_pull)
  );

  wor_xcvr_rx #(.W(W)) rx_i (
    .clk(clk), .rst(rst), .oe_req(loc_oe_req), .wire_lvl(bus_wire),
    .dout(loc_out), .oe(loc_oe)
  );
endmodule

// File: rtl/wor_xcvr_chk.sv
module wor_xcvr_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] loc_in,
  input logic [W-1:0] loc_out,
  input logic [W-1:0] loc_oe,
  input logic         path_bypass,
  input logic         lat_open_n,
  input logic         bus_en_p,
  input logic         bus_en_n,
  input logic         loc_oe_req,
  input logic [W-1:0] bus_wire,
  input logic [W-1:0] bus_pull
);
  assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
    (path_bypass && bus_en_p && !bus_en_n) |=> (bus_pull == $past(loc_in)));

  assert_release_R2: assert property (@(posedge clk) disable iff (rst)
    !(bus_en_p && !bus_en_n) |=> (bus_pull == '0));

  assert_transparent_R3: assert property (@(posedge clk) disable iff (rst)
    (!path_bypass && !lat_open_n && bus_en_p && !bus_en_n) |=> (bus_pull == $past(loc_in)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (lat_open_n && $past(lat_open_n) && !path_bypass && !$past(path_bypass) &&
     bus_en_p && !bus_en_n && $past(bus_en_p) && !$past(bus_en_n)) |=> $stable(bus_pull));

  assert_oe_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (loc_oe == {W{$past(loc_oe_req)}}));

  assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !loc_oe_req |=> (loc_out == '0));

  assert_readback_R6: assert property (@(posedge clk) disable iff (rst)
    loc_oe_req |=> (loc_out == ~$past(bus_wire)));

  assert_reset_R7: assert property (@(posedge clk)
    rst |=> (bus_pull == '0 && loc_oe == '0 && loc_out == '0));
endmodule

bind wor_xcvr wor_xcvr_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .loc_in(loc_in), .loc_out(loc_out), .loc_oe(loc_oe),
  .path_bypass(path_bypass), .lat_open_n(lat_open_n), .bus_en_p(bus_en_p),
  .bus_en_n(bus_en_n), .loc_oe_req(loc_oe_req), .bus_wire(bus_wire),
  .bus_pull(bus_pull)
);

// File: tb/wor_bus_resolve.sv
module wor_bus_resolve #(
  parameter int W = 9,
  parameter int AGENTS = 2
) (
  input  logic [AGENTS*W-1:0] pulls,
  output logic [W-1:0]        lvl
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [AGENTS-1:0] col;
    for (genvar a = 0; a < AGENTS; a++) begin : g_agent
      assign col[a] = pulls[a*W + b];
    end
    assign lvl[b] = ~(|col);
  end
endmodule

// File: tb/wor_xcvr_tb.sv
`timescale 1ns/1ps
module wor_xcvr_tb_top;
  localparam int W = 9;
  localparam int NV = 12;
  // {bypass, open_n, en_p, en_n, oe_req, din, other, exp_pull, exp_out}
  localparam int VW = 5 + 4*W;
  localparam logic [VW-1:0] TBL [NV] = '{
    {5'b11101, 9'h0A5, 9'h000, 9'h0A5, 9'h0A5}, // R1 bypass
    {5'b11101, 9'h15A, 9'h001, 9'h15A, 9'h15B}, // R1 R6 R8 other agent
    {5'b00101, 9'h123, 9'h000, 9'h123, 9'h123}, // R3 transparent
    {5'b01101, 9'h0FF, 9'h000, 9'h123, 9'h123}, // R4 hold
    {5'b01001, 9'h0FF, 9'h100, 9'h000, 9'h100}, // R2 en_p low
    {5'b01111, 9'h0FF, 9'h000, 9'h000, 9'h000}, // R2 en_n high
    {5'b01101, 9'h1FF, 9'h000, 9'h123, 9'h123}, // R4 kept across disable
    {5'b01100, 9'h1FF, 9'h000, 9'h123, 9'h000}, // R5 local off
    {5'b11101, 9'h000, 9'h1FF, 9'h000, 9'h1FF}, // R6 readback of others
    {5'b00101, 9'h055, 9'h000, 9'h055, 9'h055}, // R3 reload
    {5'b11101, 9'h0AA, 9'h000, 9'h0AA, 9'h0AA}, // R1 bypass, store closed
    {5'b01101, 9'h000, 9'h000, 9'h055, 9'h055}  // R4 store intact after bypass
  };

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] loc_in, loc_out, loc_oe, bus_wire, bus_pull, other_pull;
  logic path_bypass, lat_open_n, bus_en_p, bus_en_n, loc_oe_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wor_bus_resolve #(.W(W), .AGENTS(2)) res_i (.pulls({other_pull, bus_pull}), .lvl(bus_wire));

  wor_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .loc_in(loc_in), .loc_out(loc_out), .loc_oe(loc_oe),
    .path_bypass(path_bypass), .lat_open_n(lat_open_n), .bus_en_p(bus_en_p),
    .bus_en_n(bus_en_n), .loc_oe_req(loc_oe_req), .bus_wire(bus_wire),
    .bus_pull(bus_pull)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step2;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; loc_in = '0; other_pull = '0; path_bypass = 1'b0;
    lat_open_n = 1'b1; bus_en_p = 1'b1; bus_en_n = 1'b0; loc_oe_req = 1'b1;
    step2;
    check("R7 reset pull", bus_pull, '0);
    check("R7 reset oe", loc_oe, '0);
    check("R7 reset out", loc_out, '0);
    rst = 1'b0;
    step2;
    check("R7 cleared store keeps bus released", bus_pull, '0);
    check("R8 idle wire high", bus_wire, '1);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = TBL[k];
      {path_bypass, lat_open_n, bus_en_p, bus_en_n, loc_oe_req} = v[VW-1 -: 5];
      loc_in = v[4*W-1 -: W];
      other_pull = v[3*W-1 -: W];
      step2;
      check($sformatf("R1 R2 R3 R4 pull vec%0d", k), bus_pull, v[2*W-1 -: W]);
      check($sformatf("R5 R6 out vec%0d", k), loc_out, v[W-1:0]);
      check($sformatf("R5 oe vec%0d", k), loc_oe, loc_oe_req ? '1 : '0);
      check($sformatf("R8 wire vec%0d", k), bus_wire, ~(bus_pull | other_pull));
    end

    // R7: reset mid-operation clears the stored word
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 mid reset pull", bus_pull, '0);
    check("R7 mid reset oe", loc_oe, '0);
    rst = 1'b0; path_bypass = 1'b0; lat_open_n = 1'b1; loc_in = 9'h1FF;
    step2;
    check("R7 store cleared", bus_pull, '0);

    // R4: store captures the word from the last open cycle before closing
    lat_open_n = 1'b0; loc_in = 9'h0C3;
    @(posedge clk); @(negedge clk);
    lat_open_n = 1'b1; loc_in = 9'h03C;
    step2;
    check("R4 capture at close", bus_pull, 9'h0C3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule